// File: doc/BRIEF.md
# Edge-Capture Period-Trimming Phase Lock

This block keeps a free-running reference timer in step with an external square wave such as a shaped mains signal. The timer counts from zero up to an active period value and wraps. Each selected transition of the external input (rising or falling, chosen by a control pin) freezes the running count. That frozen count, less a programmable phase setpoint, is the phase error. A fixed-point proportional-integral regulator turns the error into a trim. The trim is added to a nominal period, clamped to a programmable window, and loaded into the timer at its next wrap. The timer's cycle therefore stretches or shrinks until the external edge lands on the setpoint count.

The loop is meant to run slowly, with small gains, so phase moves gently. A lock flag reports that a run of consecutive captures all fell inside a programmable error band. The flag drops if a capture falls outside the band, or if the input goes quiet for twice the nominal period.

Top module: `edge_phase_lock`

## Requirements
- R1: The square-wave input passes through a two-flop synchronizer. When `edge_sel` is 0 a low-to-high transition is selected, and when it is 1 a high-to-low transition is selected. The count captured is the `count_o` value visible in the second clock cycle after the input changes, and exactly one capture is taken per selected transition.
- R2: `count_o` rises by one each clock. After `count_o` equals `period_o` it returns to 0, so one timer cycle lasts `period_o + 1` clocks.
- R3: `period_o` changes only on the clock where `count_o` wraps to 0. It then takes the most recent regulator result.
- R4: The phase error is the captured count minus `setpoint`, as a signed value.
- R5: With `FRAC_W` fraction bits, the integrator first grows by `ki*err`. The next period is then `nom_period + floor((kp*err + integrator) / 2^FRAC_W)`. `kp` and `ki` are unsigned.
- R6: The integrator saturates symmetrically at `±(2^(INT_W-1) - 1)`.
- R7: The regulator result is clamped to the range [`min_period`, `max_period`] before it is loaded.
- R8: `locked_o` rises after `LOCK_N` consecutive captures with |error| < `lock_thresh`. It falls on any capture with |error| ≥ `lock_thresh`.
- R9: `locked_o` falls, and the run of good captures restarts, when no selected transition arrives for `2*nom_period` clocks.
- R10: Synchronous active-low reset gives `count_o` = 0, `period_o` = `nom_period`, `locked_o` = 0 and a zero integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sq_in | input | 1 | Asynchronous external square wave |
| edge_sel | input | 1 | 0 selects rising transitions, 1 selects falling |
| setpoint | input | CNT_W | Desired count at the selected transition |
| kp | input | GAIN_W | Proportional gain (unsigned, FRAC_W fraction bits) |
| ki | input | GAIN_W | Integral gain (unsigned, FRAC_W fraction bits) |
| nom_period | input | CNT_W | Nominal period value |
| min_period | input | CNT_W | Lower clamp for the trimmed period |
| max_period | input | CNT_W | Upper clamp for the trimmed period |
| lock_thresh | input | CNT_W | Error magnitude bound for a good capture |
| count_o | output | CNT_W | Running timer count |
| period_o | output | CNT_W | Active period value |
| locked_o | output | 1 | Lock indication |

## Verification
The loop is driven with square waves whose period is drawn at random around the nominal value, on rising transitions and then on falling ones. A wrong capture instant or a wrong edge polarity shows up as a period mismatch at the next wrap. Large proportional gain drives the result into both clamp limits. A long run of one-signed error with a large integral gain, followed by a reversal of the setpoint, separates a saturating integrator from one that wraps or grows without bound. Switching the lock band from wide to zero, and then stopping the input, tells the error-band release apart from the silence timeout.

// File: rtl/epl_pkg.sv
package epl_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ERR   = 2'd1,
      SQ_TERMS = 2'd2,
      SQ_CLAMP = 2'd3
   } seq_state_e;
endpackage

// File: rtl/epl_edge_sync.sv
module epl_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sq_in,
   input  logic edge_sel,
   output logic edge_pulse
);
   localparam int CHAIN_W = STAGES + 1;

   logic [CHAIN_W-1:0] chain;
   logic               cur_lvl;
   logic               old_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[CHAIN_W-2:0], sq_in};
   end

   assign cur_lvl = chain[STAGES-1];
   assign old_lvl = chain[STAGES];

   generate
      if (STAGES >= 2) begin : g_edge
         assign edge_pulse = edge_sel ? (old_lvl & ~cur_lvl) : (cur_lvl & ~old_lvl);
      end else begin : g_edge_bad
         assign edge_pulse = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/epl_period_timer.sv
module epl_period_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] nom_period,
   input  logic [CNT_W-1:0] pend_period,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] period_act
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count      <= '0;
         period_act <= nom_period;
      end else if (count == period_act) begin
         count      <= '0;
         period_act <= pend_period;
      end else begin
         count      <= count + 1'b1;
      end
   end
endmodule

// File: rtl/epl_pi_trim.sv
module epl_pi_trim
   import epl_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int GAIN_W = 8,
   parameter int INT_W  = 24,
   parameter int FRAC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               edge_pulse,
   input  logic [CNT_W-1:0]   count,
   input  logic [CNT_W-1:0]   setpoint,
   input  logic [GAIN_W-1:0]  kp,
   input  logic [GAIN_W-1:0]  ki,
   input  logic [CNT_W-1:0]   nom_period,
   input  logic [CNT_W-1:0]   min_period,
   input  logic [CNT_W-1:0]   max_period,
   output logic [CNT_W-1:0]   pend_period,
   output logic signed [CNT_W:0] err,
   output logic               err_vld
);
   localparam int PROD_W = CNT_W + GAIN_W + 2;
   localparam int W      = ((PROD_W > INT_W) ? PROD_W : INT_W) + 2;
   localparam longint I_MAX_L = (64'sd1 <<< (INT_W - 1)) - 64'sd1;

   seq_state_e          state;
   logic [CNT_W-1:0]    cap;
   logic signed [W-1:0] prop_q;
   logic signed [INT_W-1:0] integ_q;

   logic signed [W-1:0] err_w, kp_w, ki_w, i_max, i_min;
   logic signed [W-1:0] prop_d, integ_sum, integ_sat;
   logic signed [W-1:0] sum_w, trim_w, cand_w, nom_w, lo_w, hi_w;
   logic [CNT_W-1:0]    clamped;

   always_comb begin
      err_w     = W'(err);
      kp_w      = W'(kp);
      ki_w      = W'(ki);
      i_max     = W'(I_MAX_L);
      i_min     = -i_max;
      prop_d    = kp_w * err_w;
      integ_sum = W'(integ_q) + ki_w * err_w;
      if (integ_sum > i_max)      integ_sat = i_max;
      else if (integ_sum < i_min) integ_sat = i_min;
      else                        integ_sat = integ_sum;
      sum_w     = prop_q + W'(integ_q);
      nom_w     = W'(nom_period);
      lo_w      = W'(min_period);
      hi_w      = W'(max_period);
   end

   generate
      if (FRAC_W == 0) begin : g_no_frac
         assign trim_w = sum_w;
      end else begin : g_frac
         assign trim_w = sum_w >>> FRAC_W;
      end
   endgenerate

   always_comb begin
      cand_w = nom_w + trim_w;
      if (cand_w < lo_w)      clamped = min_period;
      else if (cand_w > hi_w) clamped = max_period;
      else                    clamped = cand_w[CNT_W-1:0];
   end

   assign err_vld = (state == SQ_TERMS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= SQ_IDLE;
         cap         <= '0;
         err         <= '0;
         prop_q      <= '0;
         integ_q     <= '0;
         pend_period <= nom_period;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (edge_pulse) begin
                  cap   <= count;
                  state <= SQ_ERR;
               end
            end
            SQ_ERR: begin
               err   <= $signed({1'b0, cap}) - $signed({1'b0, setpoint});
               state <= SQ_TERMS;
            end
            SQ_TERMS: begin
               prop_q  <= prop_d;
               integ_q <= integ_sat[INT_W-1:0];
               state   <= SQ_CLAMP;
            end
            SQ_CLAMP: begin
               pend_period <= clamped;
               state       <= SQ_IDLE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/epl_lock_mon.sv
module epl_lock_mon #(
   parameter int CNT_W  = 16,
   parameter int LOCK_N = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 edge_pulse,
   input  logic                 err_vld,
   input  logic signed [CNT_W:0] err,
   input  logic [CNT_W-1:0]     lock_thresh,
   input  logic [CNT_W-1:0]     nom_period,
   output logic                 locked
);
   localparam int GOOD_W = $clog2(LOCK_N + 1);
   localparam int TMO_W  = CNT_W + 2;
   localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(LOCK_N);

   logic [GOOD_W-1:0] good_cnt;
   logic [TMO_W-1:0]  quiet_cnt;
   logic [TMO_W-1:0]  quiet_lim;
   logic              quiet_hit;
   logic [CNT_W:0]    mag;
   logic              in_band;

   assign quiet_lim = {1'b0, nom_period, 1'b0};
   assign quiet_hit = (quiet_cnt >= quiet_lim);
   assign mag       = err[CNT_W] ? $unsigned(-err) : $unsigned(err);
   assign in_band   = (mag < {1'b0, lock_thresh});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_cnt <= '0;
      end else if (edge_pulse) begin
         quiet_cnt <= '0;
      end else if (!quiet_hit) begin
         quiet_cnt <= quiet_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || quiet_hit) begin
         good_cnt <= '0;
         locked   <= 1'b0;
      end else if (err_vld) begin
         if (in_band) begin
            if (good_cnt != GOOD_TOP) good_cnt <= good_cnt + 1'b1;
            locked <= (good_cnt >= GOOD_TOP - 1'b1);
         end else begin
            good_cnt <= '0;
            locked   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/edge_phase_lock.sv
module edge_phase_lock #(
   parameter int CNT_W       = 16,
   parameter int GAIN_W      = 8,
   parameter int INT_W       = 24,
   parameter int FRAC_W      = 8,
   parameter int LOCK_N      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sq_in,
   input  logic              edge_sel,
   input  logic [CNT_W-1:0]  setpoint,
   input  logic [GAIN_W-1:0] kp,
   input  logic [GAIN_W-1:0] ki,
   input  logic [CNT_W-1:0]  nom_period,
   input  logic [CNT_W-1:0]  min_period,
   input  logic [CNT_W-1:0]  max_period,
   input  logic [CNT_W-1:0]  lock_thresh,
   output logic [CNT_W-1:0]  count_o,
   output logic [CNT_W-1:0]  period_o,
   output logic              locked_o
);
   initial begin : elab_checks
      assert (CNT_W >= 4 && CNT_W <= 30) else $error("CNT_W out of range");
      assert (GAIN_W >= 1 && GAIN_W <= 16) else $error("GAIN_W out of range");
      assert (INT_W >= 4 && INT_W <= 40) else $error("INT_W out of range");
      assert (FRAC_W >= 0 && FRAC_W < INT_W) else $error("FRAC_W must be below INT_W");
      assert (LOCK_N >= 1) else $error("LOCK_N must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic                 edge_pulse;
   logic [CNT_W-1:0]     pend_period;
   logic signed [CNT_W:0] err;
   logic                 err_vld;

   epl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sq_in(sq_in), .edge_sel(edge_sel),
      .edge_pulse(edge_pulse)
   );

   epl_period_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .nom_period(nom_period),
      .pend_period(pend_period), .count(count_o), .period_act(period_o)
   );

   epl_pi_trim #(.CNT_W(CNT_W), .GAIN_W(GAIN_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_pi (
      .clk(clk), .rst_n(rst_n), .edge_pulse(edge_pulse), .count(count_o),
      .setpoint(setpoint), .kp(kp), .ki(ki), .nom_period(nom_period),
      .min_period(min_period), .max_period(max_period),
      .pend_period(pend_period), .err(err), .err_vld(err_vld)
   );

   epl_lock_mon #(.CNT_W(CNT_W), .LOCK_N(LOCK_N)) u_lock (
      .clk(clk), .rst_n(rst_n), .edge_pulse(edge_pulse), .err_vld(err_vld),
      .err(err), .lock_thresh(lock_thresh), .nom_period(nom_period),
      .locked(locked_o)
   );
endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] period_o,
   input logic [CNT_W-1:0] min_period,
   input logic [CNT_W-1:0] max_period,
   input logic             locked_o,
   input logic             err_vld
);
   // R2: wrap to zero after the active period
   p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == period_o) |=> (count_o == '0));

   // R2: single-step counting between wraps
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != period_o) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

   // R3: period only moves at a wrap
   p_period_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o != period_o) |=> $stable(period_o));

   // R7: any newly loaded period lies in the clamp window
   p_period_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(period_o) |-> (period_o >= min_period && period_o <= max_period));

   // R8: lock only rises right after an error evaluation
   p_lock_after_eval_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(err_vld));
endmodule

bind edge_phase_lock epl_checker #(.CNT_W(CNT_W)) u_epl_checker (
   .clk(clk), .rst_n(rst_n), .count_o(count_o), .period_o(period_o),
   .min_period(min_period), .max_period(max_period),
   .locked_o(locked_o), .err_vld(err_vld)
);

// File: tb/edge_phase_lock_bench.sv
module edge_phase_lock_bench;
   localparam int CW = 16;
   localparam int GW = 8;
   localparam int IW = 20;
   localparam int FW = 8;
   localparam int LN = 4;
   localparam int NOM = 500;
   localparam int PMIN = 400;
   localparam int PMAX = 600;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, sq_in, edge_sel;
   logic [CW-1:0] setpoint, nom_period, min_period, max_period, lock_thresh;
   logic [GW-1:0] kp, ki;
   logic [CW-1:0] count_o, period_o;
   logic locked_o;

   edge_phase_lock #(.CNT_W(CW), .GAIN_W(GW), .INT_W(IW), .FRAC_W(FW), .LOCK_N(LN)) u_edge_phase_lock (
      .clk(clk), .rst_n(rst_n), .sq_in(sq_in), .edge_sel(edge_sel),
      .setpoint(setpoint), .kp(kp), .ki(ki), .nom_period(nom_period),
      .min_period(min_period), .max_period(max_period), .lock_thresh(lock_thresh),
      .count_o(count_o), .period_o(period_o), .locked_o(locked_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   longint m_integ;
   int m_good;
   logic m_lock;
   longint exp_pend, pend_nxt, wrap_exp;
   int pend_cd;
   bit wrap_due;
   int unsigned seed_val;

   task automatic check(string req, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // one clock, sampled at the falling edge
   task automatic tick();
      @(negedge clk);
      if (wrap_due) begin
         check("R3 period at wrap", period_o, wrap_exp);
         check("R2 count wraps to zero", count_o, 0);
      end
      if (pend_cd > 0) begin
         pend_cd--;
         if (pend_cd == 0) exp_pend = pend_nxt;
      end
      wrap_due = (count_o == period_o);
      wrap_exp = exp_pend;
   endtask

   function automatic longint clampv(longint v, longint lo, longint hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // R4 R5 R6 R7 R8 reference from the requirements
   task automatic model_capture(longint cap);
      longint e, p, ia, imax, trim, mag;
      imax = (64'sd1 <<< (IW - 1)) - 1;
      e    = cap - longint'(setpoint);
      p    = longint'(kp) * e;
      ia   = clampv(m_integ + longint'(ki) * e, -imax, imax);
      m_integ = ia;
      trim = (p + m_integ) >>> FW;
      pend_nxt = clampv(longint'(nom_period) + trim, longint'(min_period), longint'(max_period));
      pend_cd = 4;
      mag = (e < 0) ? -e : e;
      if (mag < longint'(lock_thresh)) begin
         if (m_good < LN) m_good++;
      end else begin
         m_good = 0;
      end
      m_lock = (m_good >= LN);
   endtask

   // one input period of 2*h clocks, selected transition first (R1)
   task automatic do_period(int h, string req);
      logic lvl;
      longint cap;
      lvl = edge_sel ? 1'b0 : 1'b1;
      if (sq_in == lvl) begin
         sq_in = ~lvl;
         repeat (4) tick();
      end
      tick();
      sq_in = lvl;
      tick();
      tick();
      cap = longint'(count_o);
      model_capture(cap);
      repeat (4) tick();
      check({req, " R8 lock flag"}, locked_o, m_lock);
      repeat (h - 6) tick();
      sq_in = ~lvl;
      repeat (h) tick();
   endtask

   initial begin : watchdog
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin : stim
      seed_val = 32'd1234;
      void'($urandom(seed_val));
      rst_n = 1'b0; sq_in = 1'b0; edge_sel = 1'b0;
      setpoint = 16'd250; kp = 8'd16; ki = 8'd1;
      nom_period = NOM; min_period = PMIN; max_period = PMAX;
      lock_thresh = 16'd600;
      m_integ = 0; m_good = 0; m_lock = 1'b0;
      exp_pend = NOM; pend_nxt = NOM; wrap_exp = NOM; pend_cd = 0; wrap_due = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 reset count", count_o, 0);
      check("R10 reset period", period_o, NOM);
      check("R10 reset lock", locked_o, 0);
      rst_n = 1'b1;

      // rising edges, mild gains, random input periods
      for (int i = 0; i < 12; i++) do_period(220 + int'($urandom_range(0, 60)), "R1 R5 rising");

      // zero band releases lock on the next capture
      lock_thresh = 16'd0;
      do_period(250, "R8 band release");
      lock_thresh = 16'd600;

      // falling edges
      edge_sel = 1'b1;
      for (int i = 0; i < 8; i++) do_period(220 + int'($urandom_range(0, 60)), "R1 R4 falling");
      edge_sel = 1'b0;

      // big proportional gain drives the clamps
      kp = 8'd255; ki = 8'd0;
      for (int i = 0; i < 8; i++) do_period(220 + int'($urandom_range(0, 60)), "R7 clamp");

      // integrator pinned at its limit, then reversed
      kp = 8'd0; ki = 8'd255; setpoint = 16'd0;
      for (int i = 0; i < 10; i++) do_period(220 + int'($urandom_range(0, 60)), "R6 saturate high");
      setpoint = 16'd600;
      for (int i = 0; i < 10; i++) do_period(220 + int'($urandom_range(0, 60)), "R6 recover");

      // regain lock, then remove the input
      kp = 8'd16; ki = 8'd1; setpoint = 16'd250;
      for (int i = 0; i < 5; i++) do_period(250, "R8 relock");
      check("R8 locked before silence", locked_o, 1);
      repeat (1100) tick();
      check("R9 silence timeout", locked_o, 0);
      m_good = 0; m_lock = 1'b0;
      do_period(250, "R9 after timeout");

      finish_run();
   end
endmodule